// File: doc/BRIEF.md
# Masked interrupt flag controller

The block gathers up to 32 single-cycle interrupt source pulses into a sticky flag register. It combines those flags with a 32-bit enable mask and a one-bit master enable, and from them drives one registered interrupt request to the processor. A separate wake output pulses whenever any source fires, so a halted processor resumes even if that source is masked or interrupts are globally off.

Software reaches the state through a 16-bit register port. The port is addressed by halfword index. Index 0 is the master enable, 1 and 2 are the low and high enable halves, and 3 and 4 are the low and high flag halves. Flags are cleared by writing ones. A wide access (`wide_i` high) to the low-half index of the enable or flag pair also writes the high half, taking `wdata_i[31:16]`, in the same cycle. Reads are combinational on `addr_i`.

Top module: `irq_ctl`

## Requirements
- R1: A pulse on `src_i[k]` sets flag bit k at the next clock edge. Bits 0..15 read back at index 3 and bits 16..31 at index 4. Flags never become set by any other means.
- R2: A write to a flag index clears each flag bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When a source pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R4: `irq_o` is high in a cycle exactly when, in the previous cycle, master enable bit 0 was 1 and (enable AND flag) was nonzero.
- R5: A write to the master enable or to either enable half that leaves an enabled flag pending raises `irq_o` on the second clock edge after the write is presented, without any new source pulse.
- R6: `wake_o` is high in a cycle exactly when any `src_i` bit was high in the previous cycle, regardless of master enable and enable mask.
- R7: A write with `wide_i`=1 to index 1 stores `wdata_i[15:0]` in the low enable half and `wdata_i[31:16]` in the high half. The same wide write to index 3 clears flags in both halves. At any other index, `wide_i` has no effect.
- R8: The master enable stores only write-data bit 0, and index 0 reads back 0 in bits 15:1.
- R9: Indices 0..4 read back the stored values. Indices 5..7 read 0 and writes to them change nothing.
- R10: After reset all registers are 0, and both `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source pulses, one bit per source |
| we_i | input | 1 | Register write strobe |
| wide_i | input | 1 | Write both halves of a pair at the low index |
| addr_i | input | 3 | Halfword register index |
| wdata_i | input | 32 | Write data; upper half used only by wide writes |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Registered processor interrupt request |
| wake_o | output | 1 | Registered wake pulse |

## Verification
Four relations are checked on every cycle:
- The request follows the gated flag state of the previous cycle.
- The wake output follows any source activity of the previous cycle, high and low.
- Every pulsed source is latched.
- No flag rises without its source.

The bench's scenarios are needed for the rest:
- clear-by-one semantics and the collision rule;
- wide writes to both halves;
- the master enable's single stored bit;
- the quiet unused indices;
- the two-edge latency from an enable write to the request.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] IDX_MASTER = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_EN_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_EN_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_FL_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_FL_HI  = 3'd4;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  wide_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*HALF_W-1:0]   wdata_i,
  output logic                  me_o,
  output logic [2*HALF_W-1:0]   en_o,
  output logic [2*HALF_W-1:0]   clr_o
);
  localparam int unsigned W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_d, hi_d;
  logic              hit_me, hit_en_lo, hit_en_hi, hit_fl_lo, hit_fl_hi;
  logic              me_q;
  logic [W-1:0]      en_q;

  assign lo_d = wdata_i[HALF_W-1:0];
  assign hi_d = wdata_i[W-1:HALF_W];

  assign hit_me    = we_i && (addr_i == IDX_MASTER);
  assign hit_en_lo = we_i && (addr_i == IDX_EN_LO);
  assign hit_en_hi = we_i && ((addr_i == IDX_EN_HI) || ((addr_i == IDX_EN_LO) && wide_i));
  assign hit_fl_lo = we_i && (addr_i == IDX_FL_LO);
  assign hit_fl_hi = we_i && ((addr_i == IDX_FL_HI) || ((addr_i == IDX_FL_LO) && wide_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_q <= 1'b0;
      en_q <= '0;
    end else begin
      if (hit_me)    me_q               <= lo_d[0];
      if (hit_en_lo) en_q[HALF_W-1:0]   <= lo_d;
      if (hit_en_hi) en_q[W-1:HALF_W]   <= (addr_i == IDX_EN_LO) ? hi_d : lo_d;
    end
  end

  // clear masks for the flag bank, one per half
  always_comb begin
    clr_o = '0;
    if (hit_fl_lo) clr_o[HALF_W-1:0] = lo_d;
    if (hit_fl_hi) clr_o[W-1:HALF_W] = (addr_i == IDX_FL_LO) ? hi_d : lo_d;
  end

  assign me_o = me_q;
  assign en_o = en_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] fl_o
);
  logic [NUM_SRC-1:0] fl_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fl_q[i] <= 1'b0;
      else         fl_q[i] <= (fl_q[i] & ~clr_i[i]) | src_i[i]; // set beats clear
    end
  end

  assign fl_o = fl_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               me_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] fl_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               wake_o
);
  logic irq_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= me_i && (|(en_i & fl_i));
      wake_q <= |src_i; // ungated by design
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*HALF_W-1:0] src_i,
  input  logic                we_i,
  input  logic                wide_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int unsigned NUM_SRC = 2 * HALF_W;

  logic               me_q;
  logic [NUM_SRC-1:0] en_q, fl_q, clr;

  irq_ctl_regs #(.HALF_W(HALF_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .wide_i, .addr_i, .wdata_i,
    .me_o(me_q), .en_o(en_q), .clr_o(clr)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i, .rst_ni, .src_i, .clr_i(clr), .fl_o(fl_q)
  );

  irq_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
    .clk_i, .rst_ni, .me_i(me_q), .en_i(en_q), .fl_i(fl_q), .src_i,
    .irq_o, .wake_o
  );

  always_comb begin
    unique case (addr_i)
      IDX_MASTER: rdata_o = {{(HALF_W-1){1'b0}}, me_q};
      IDX_EN_LO:  rdata_o = en_q[HALF_W-1:0];
      IDX_EN_HI:  rdata_o = en_q[NUM_SRC-1:HALF_W];
      IDX_FL_LO:  rdata_o = fl_q[HALF_W-1:0];
      IDX_FL_HI:  rdata_o = fl_q[NUM_SRC-1:HALF_W];
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned NUM_SRC = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic               wake_o,
  input logic               me_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] fl_q
);
  AST_IRQ_FOLLOWS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(me_q && (|(en_q & fl_q))))); // R4
  AST_WAKE_ON_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> wake_o); // R6
  AST_WAKE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|src_i) |=> !wake_o); // R6
  AST_SRC_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fl_q & $past(src_i)) == $past(src_i))); // R3
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fl_q & ~$past(fl_q) & ~$past(src_i)) == '0)); // R1
endmodule

bind irq_ctl irq_ctl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i, .rst_ni, .src_i, .irq_o, .wake_o,
  .me_q(me_q), .en_q(en_q), .fl_q(fl_q)
);

// File: tb/irq_ctl_tb.sv
`timescale 1ns/1ps
module irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic        wide = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wake;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // reference state
  logic        m_me;
  logic [31:0] m_en, m_fl;
  logic        m_irq, m_wake;

  always #4 clk = ~clk;

  irq_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {15'b0, m_me};
      3'd1: return m_en[15:0];
      3'd2: return m_en[31:16];
      3'd3: return m_fl[15:0];
      3'd4: return m_fl[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_edge(input logic [31:0] s, input logic w, input logic wd,
                            input logic [2:0] a, input logic [31:0] d);
    logic [31:0] clr = '0;
    m_irq  = m_me && (|(m_en & m_fl));
    m_wake = |s;
    if (w) begin
      case (a)
        3'd0: m_me = d[0];
        3'd1: begin m_en[15:0] = d[15:0]; if (wd) m_en[31:16] = d[31:16]; end
        3'd2: m_en[31:16] = d[15:0];
        3'd3: begin clr[15:0] = d[15:0]; if (wd) clr[31:16] = d[31:16]; end
        3'd4: clr[31:16] = d[15:0];
        default: ;
      endcase
    end
    m_fl = (m_fl & ~clr) | s;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare outputs at following negedge
  task automatic cyc(input logic [31:0] s, input logic w, input logic wd,
                     input logic [2:0] a, input logic [31:0] d, input string req);
    src = s; we = w; wide = wd; addr = a; wdata = d;
    @(posedge clk);
    model_edge(s, w, wd, a, d);
    @(negedge clk);
    src = '0; we = 1'b0; wide = 1'b0;
    check({req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    check({req, " wake"}, {31'b0, wake}, {31'b0, m_wake});
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    addr = a; we = 1'b0;
    #1;
    check(req, {16'b0, rdata}, {16'b0, exp_read(a)});
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 8; a++) rd(3'(a), req);
  endtask

  task automatic idle(input string req);
    cyc('0, 1'b0, 1'b0, 3'd7, '0, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE11));
    m_me = 0; m_en = '0; m_fl = '0; m_irq = 0; m_wake = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 wake", {31'b0, wake}, 32'h0);
    rd_all("R10 reset read");
    rst_n = 1'b1;
    @(negedge clk);

    // R6 wake with everything masked; R1 latching into both halves
    cyc(32'h0001_8002, 1'b0, 1'b0, 3'd7, '0, "R6");
    check("R6 wake masked", {31'b0, wake}, 32'h1);
    check("R4 irq masked", {31'b0, irq}, 32'h0);
    rd(3'd3, "R1 flag lo");
    rd(3'd4, "R1 flag hi");
    idle("R6 quiet");

    // R7 wide enable write, R5 enable/master re-evaluate
    cyc('0, 1'b1, 1'b1, 3'd1, 32'h0001_0000, "R7");
    rd(3'd1, "R7 en lo");
    rd(3'd2, "R7 en hi");
    check("R7 en hi value", {16'b0, rdata}, 32'h0001);
    cyc('0, 1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF, "R5 master write");
    rd(3'd0, "R8 master single bit");
    check("R8 master reads 1", {16'b0, rdata}, 32'h1);
    idle("R5 irq rises");
    check("R5 irq after enable", {31'b0, irq}, 32'h1);

    // R2 clear with zeros keeps, R4 deassert the cycle after clear
    cyc('0, 1'b1, 1'b0, 3'd4, 32'h0000_0000, "R2 zero write");
    rd(3'd4, "R2 flags kept");
    cyc('0, 1'b1, 1'b0, 3'd4, 32'h0000_0001, "R2 clear");
    rd(3'd4, "R2 cleared hi");
    check("R4 still high one cycle", {31'b0, irq}, 32'h1);
    idle("R4 deassert");
    check("R4 irq low", {31'b0, irq}, 32'h0);

    // R3 collision, source wins
    cyc('0, 1'b1, 1'b0, 3'd1, 32'h0000_0002, "R3 enable");
    cyc(32'h0000_0002, 1'b1, 1'b0, 3'd3, 32'h0000_0002, "R3 collide");
    rd(3'd3, "R3 flag stays");
    check("R3 bit1 set", {31'b0, rdata[1]}, 32'h1);

    // R7 wide flag clear, R9 unused indices
    cyc(32'hF0F0_0F0F, 1'b0, 1'b0, 3'd7, '0, "R1 burst");
    cyc('0, 1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF, "R7 wide clear");
    rd_all("R7 after wide clear");
    cyc('0, 1'b1, 1'b1, 3'd5, 32'hFFFF_FFFF, "R9 unused write");
    cyc('0, 1'b1, 1'b1, 3'd2, 32'hABCD_1234, "R7 wide ignored at hi idx");
    rd_all("R9 read all");

    // R8 master off gates, R4
    cyc('0, 1'b1, 1'b0, 3'd0, 32'h0000_FFFE, "R8 master bit0 zero");
    cyc(32'h0000_0002, 1'b0, 1'b0, 3'd7, '0, "R4 gated");
    idle("R4 gated idle");
    check("R4 gated irq", {31'b0, irq}, 32'h0);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] s = $urandom & $urandom & $urandom;
      logic        w = ($urandom % 3) == 0;
      logic        wd = $urandom[0];
      logic [2:0]  a = 3'($urandom % 6);
      logic [31:0] d = $urandom;
      if (($urandom % 4) != 0) s = '0;
      cyc(s, w, wd, a, d, "R4 random");
      if ((i % 8) == 0) rd_all("R9 random read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule